// File: doc/BRIEF.md
# Interrupt Table Vector Classifier

This block turns an interrupt source into a handler entry address. A one-cycle start pulse supplies a select code, the class of the source (ordinary device, DMA channel, protection/parity trap, or timer), a parity-error flag and the program counter at the point of suspension. For device and DMA sources the block reads one word from an interrupt table in memory. The table begins at select code 6, and its base address and length come from configuration inputs. The sign and zero state of that word then choose the handler. Timer and protection sources skip the table.

Handler addresses are words in a vector block at fixed offsets from a configurable vector base. The block reads the chosen word over a single memory port with one cycle of read latency and presents its low 15 bits on a one-cycle valid pulse. With the handler it returns the table word that was used and a code for the handler that was picked. On a parity trap it first writes the suspended program counter to the vector block.

Top module: `ivc_top`

## Requirements
- R1: While reset is high and in the cycle after it falls, `out_valid`, `busy`, `mem_rd` and `mem_we` are all 0.
- R2: For source class 0 (device) or 1 (DMA), with index = select code − 6 taken modulo 2^16 and index ≤ `cfg_tbl_len`, the block makes one table read at `cfg_tbl_base` + index and then one vector read, two reads in total. `out_valid` rises four clock edges after the start edge. An index equal to the length is still read.
- R3: When the index exceeds `cfg_tbl_len`, including select codes below 6, no table read is made. The entry is 0, the illegal handler is chosen, and `out_valid` rises two edges after the start edge.
- R4: A table word with bit 15 set selects the scheduler handler at vector offset 6, with `out_kind` = 3.
- R5: A nonzero table word with bit 15 clear selects the device handler at vector offset 5, with `out_kind` = 2.
- R6: A zero table word selects the illegal-interrupt handler at vector offset 4, with `out_kind` = 1.
- R7: For a DMA source, bit 15 of the fetched word is cleared before classification and in `out_entry`, so the scheduler handler is never chosen.
- R8: For source class 2 (protection) with `parity_err` = 1, the block writes {0, `susp_pc`} to `cfg_vec_base` + 8. It then selects the parity handler at offset 9 (`out_kind` = 5), and `out_valid` rises three edges after start.
- R9: For source class 2 with `parity_err` = 0, the block selects the request handler at offset 7 (`out_kind` = 4) with no memory write, and `out_valid` rises two edges after start.
- R10: For source class 3 (timer), the block selects the clock handler at offset 3 (`out_kind` = 0) with one read and no table access, and `out_valid` rises two edges after start.
- R11: `out_handler` is bits 14:0 of the vector word read, so bit 15 of that word is dropped. `out_valid` is high for exactly one cycle per accepted request.
- R12: A start pulse while `busy` is high is ignored. It neither changes the result in progress nor produces a second valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| sel_code | input | 6 | Interrupting select code |
| irq_src | input | 2 | Source class: 0 device, 1 DMA, 2 protection/parity, 3 timer |
| parity_err | input | 1 | Parity error flag for protection traps |
| susp_pc | input | 15 | Program counter at suspension |
| cfg_tbl_base | input | 15 | Interrupt table base address (select code 6) |
| cfg_tbl_len | input | 16 | Largest valid table index |
| cfg_vec_base | input | 15 | Handler vector block base address |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | A request is in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_handler | output | 15 | Selected handler address |
| out_entry | output | 16 | Table word used for classification |
| out_kind | output | 3 | Handler code 0..5 |

## Verification
A wrong sequencer state shows up as a wrong count of reads or writes between the start pulse and the valid strobe, or as a valid strobe that arrives on the wrong edge. Both are visible within four cycles of the request. A wrong latched entry or a bad sign strip shows at the strobe as a handler code that disagrees with `out_entry` and as the wrong vector word in `out_handler`. Each path is driven with its own table contents, so a mistake in the bounds test or the offset mapping gives a different handler value on that same strobe.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int IVC_DW = 16;
    localparam int IVC_AW = 15;
    localparam int IVC_OFF_W = 4;
    localparam logic [IVC_OFF_W-1:0] OFF_SAVE_PC = 4'd8;

    typedef enum logic [1:0] {
        SRC_DEV   = 2'd0,
        SRC_DMA   = 2'd1,
        SRC_PROT  = 2'd2,
        SRC_TIMER = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        HK_TIMER   = 3'd0,
        HK_ILLEGAL = 3'd1,
        HK_DEVICE  = 3'd2,
        HK_SCHED   = 3'd3,
        HK_REQUEST = 3'd4,
        HK_PARITY  = 3'd5
    } hkind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TREQ,
        ST_TCAP,
        ST_SAVE,
        ST_VREQ,
        ST_VCAP
    } st_e;

    // Word offset of each handler inside the vector block.
    function automatic logic [IVC_OFF_W-1:0] vec_offset(input hkind_e k);
        case (k)
            HK_TIMER:   return 4'd3;
            HK_ILLEGAL: return 4'd4;
            HK_DEVICE:  return 4'd5;
            HK_SCHED:   return 4'd6;
            HK_REQUEST: return 4'd7;
            HK_PARITY:  return 4'd9;
            default:    return 4'd4;
        endcase
    endfunction

    // Sign set: program identifier; zero: no owner; otherwise a device record.
    function automatic hkind_e classify_word(input logic [IVC_DW-1:0] w);
        if (w[IVC_DW-1])
            return HK_SCHED;
        else if (w == '0)
            return HK_ILLEGAL;
        else
            return HK_DEVICE;
    endfunction

endpackage

// File: rtl/ivc_index.sv
module ivc_index
    import ivc_pkg::*;
#(
    parameter int SC_W     = 6,
    parameter int DW       = IVC_DW,
    parameter int AW       = IVC_AW,
    parameter int SC_FIRST = 6
) (
    input  logic [SC_W-1:0] sel_code,
    input  logic [AW-1:0]   tbl_base,
    input  logic [DW-1:0]   tbl_len,
    output logic            in_range,
    output logic [AW-1:0]   tbl_addr
);
    localparam logic [DW-1:0] FIRST_W = DW'(SC_FIRST);

    logic [DW-1:0] idx;

    // Modulo subtraction: codes below the first table slot wrap high
    // and fall out of range.
    always_comb begin
        idx      = DW'(sel_code) - FIRST_W;
        in_range = (idx <= tbl_len);
        tbl_addr = tbl_base + idx[AW-1:0];
    end
endmodule

// File: rtl/ivc_class.sv
module ivc_class
    import ivc_pkg::*;
#(
    parameter int DW = IVC_DW,
    parameter int AW = IVC_AW
) (
    input  src_e          src,
    input  logic          perr,
    input  logic [DW-1:0] entry,
    input  logic [AW-1:0] vec_base,
    output hkind_e        kind,
    output logic [AW-1:0] vec_addr,
    output logic [AW-1:0] save_addr
);
    always_comb begin
        case (src)
            SRC_TIMER: kind = HK_TIMER;
            SRC_PROT:  kind = perr ? HK_PARITY : HK_REQUEST;
            default:   kind = classify_word(entry);
        endcase
        vec_addr  = vec_base + AW'(vec_offset(kind));
        save_addr = vec_base + AW'(OFF_SAVE_PC);
    end
endmodule

// File: rtl/ivc_seq.sv
module ivc_seq
    import ivc_pkg::*;
#(
    parameter int DW = IVC_DW,
    parameter int AW = IVC_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  src_e          src_in,
    input  logic          perr_in,
    input  logic [AW-1:0] pc_in,
    input  logic          in_range,
    input  logic [AW-1:0] tbl_addr,
    input  hkind_e        kind_i,
    input  logic [AW-1:0] vec_addr,
    input  logic [AW-1:0] save_addr,
    input  logic [DW-1:0] mem_rdata,
    output src_e          src_q,
    output logic          perr_q,
    output logic [DW-1:0] entry_q,
    output logic          mem_rd,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          out_valid,
    output logic [AW-1:0] out_handler,
    output hkind_e        out_kind
);
    st_e           st;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] taddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            src_q       <= SRC_DEV;
            perr_q      <= 1'b0;
            pc_q        <= '0;
            taddr_q     <= '0;
            entry_q     <= '0;
            out_valid   <= 1'b0;
            out_handler <= '0;
            out_kind    <= HK_TIMER;
        end else begin
            out_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        src_q   <= src_in;
                        perr_q  <= perr_in;
                        pc_q    <= pc_in;
                        taddr_q <= tbl_addr;
                        entry_q <= '0;
                        case (src_in)
                            SRC_DEV, SRC_DMA: st <= in_range ? ST_TREQ : ST_VREQ;
                            SRC_PROT:         st <= perr_in ? ST_SAVE : ST_VREQ;
                            default:          st <= ST_VREQ;
                        endcase
                    end
                end
                ST_TREQ: st <= ST_TCAP;
                ST_TCAP: begin
                    if (src_q == SRC_DMA)
                        entry_q <= {1'b0, mem_rdata[DW-2:0]};
                    else
                        entry_q <= mem_rdata;
                    st <= ST_VREQ;
                end
                ST_SAVE: st <= ST_VREQ;
                ST_VREQ: st <= ST_VCAP;
                ST_VCAP: begin
                    out_valid   <= 1'b1;
                    out_handler <= mem_rdata[AW-1:0];
                    out_kind    <= kind_i;
                    st          <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st != ST_IDLE);
        mem_rd    = (st == ST_TREQ) || (st == ST_VREQ);
        mem_we    = (st == ST_SAVE);
        mem_wdata = (st == ST_SAVE) ? DW'(pc_q) : '0;
        case (st)
            ST_TREQ: mem_addr = taddr_q;
            ST_SAVE: mem_addr = save_addr;
            ST_VREQ: mem_addr = vec_addr;
            default: mem_addr = '0;
        endcase
    end

    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    a_r4_sched_negative: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == HK_SCHED) |-> entry_q[DW-1]);
    a_r5_device_positive: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == HK_DEVICE) |-> (entry_q != '0 && !entry_q[DW-1]));
    a_r6_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == HK_ILLEGAL) |-> (entry_q == '0));
    a_r7_dma_no_sched: assert property (@(posedge clk) disable iff (rst)
        (out_valid && src_q == SRC_DMA) |-> (out_kind != HK_SCHED));
    a_r8_write_parity_only: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (perr_q && src_q == SRC_PROT));
    a_r10_table_read_source: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && st == ST_TREQ) |-> (src_q == SRC_DEV || src_q == SRC_DMA));
    a_r12_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(src_q));
    a_r1_port_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_we}));
endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int SC_W     = 6,
    parameter int DW       = IVC_DW,
    parameter int AW       = IVC_AW,
    parameter int SC_FIRST = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [SC_W-1:0] sel_code,
    input  logic [1:0]      irq_src,
    input  logic            parity_err,
    input  logic [AW-1:0]   susp_pc,
    input  logic [AW-1:0]   cfg_tbl_base,
    input  logic [DW-1:0]   cfg_tbl_len,
    input  logic [AW-1:0]   cfg_vec_base,
    output logic            mem_rd,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            out_valid,
    output logic [AW-1:0]   out_handler,
    output logic [DW-1:0]   out_entry,
    output logic [2:0]      out_kind
);
    logic          in_range;
    logic [AW-1:0] tbl_addr;
    logic [AW-1:0] vec_addr;
    logic [AW-1:0] save_addr;
    hkind_e        kind_c;
    hkind_e        kind_q;
    src_e          src_q;
    logic          perr_q;
    logic [DW-1:0] entry_q;

    ivc_index #(.SC_W(SC_W), .DW(DW), .AW(AW), .SC_FIRST(SC_FIRST)) u_index (
        .sel_code (sel_code),
        .tbl_base (cfg_tbl_base),
        .tbl_len  (cfg_tbl_len),
        .in_range (in_range),
        .tbl_addr (tbl_addr)
    );

    ivc_class #(.DW(DW), .AW(AW)) u_class (
        .src       (src_q),
        .perr      (perr_q),
        .entry     (entry_q),
        .vec_base  (cfg_vec_base),
        .kind      (kind_c),
        .vec_addr  (vec_addr),
        .save_addr (save_addr)
    );

    ivc_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .src_in      (src_e'(irq_src)),
        .perr_in     (parity_err),
        .pc_in       (susp_pc),
        .in_range    (in_range),
        .tbl_addr    (tbl_addr),
        .kind_i      (kind_c),
        .vec_addr    (vec_addr),
        .save_addr   (save_addr),
        .mem_rdata   (mem_rdata),
        .src_q       (src_q),
        .perr_q      (perr_q),
        .entry_q     (entry_q),
        .mem_rd      (mem_rd),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .out_valid   (out_valid),
        .out_handler (out_handler),
        .out_kind    (kind_q)
    );

    assign out_entry = entry_q;
    assign out_kind  = kind_q;

    a_r3_valid_not_busy: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !busy);
endmodule

// File: tb/sim_ivc_top.sv
module sim_ivc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  sel_code = '0;
    logic [1:0]  irq_src = '0;
    logic        parity_err = 1'b0;
    logic [14:0] susp_pc = '0;
    logic [14:0] cfg_tbl_base = 15'h0100;
    logic [15:0] cfg_tbl_len = 16'd4;
    logic [14:0] cfg_vec_base = 15'h0200;
    logic        mem_rd, mem_we, busy, out_valid;
    logic [14:0] mem_addr, out_handler;
    logic [15:0] mem_wdata, out_entry;
    logic [15:0] mem_rdata = '0;
    logic [2:0]  out_kind;

    int n_chk = 0;
    int n_fail = 0;
    int rd_total = 0;
    int we_total = 0;
    logic [14:0] last_waddr = '0;
    logic [15:0] last_wdata = '0;
    logic [15:0] mem [0:1023];

    always #4 clk = ~clk;

    ivc_top u0 (
        .clk(clk), .rst(rst), .start(start), .sel_code(sel_code),
        .irq_src(irq_src), .parity_err(parity_err), .susp_pc(susp_pc),
        .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_len(cfg_tbl_len),
        .cfg_vec_base(cfg_vec_base), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .out_valid(out_valid), .out_handler(out_handler),
        .out_entry(out_entry), .out_kind(out_kind)
    );

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[9:0]];
            rd_total  <= rd_total + 1;
        end
        if (mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            we_total   <= we_total + 1;
            last_waddr <= mem_addr;
            last_wdata <= mem_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int lat, rds, wes;

    task automatic do_op(input logic [5:0] sc, input logic [1:0] src,
                         input logic perr, input logic [14:0] pc);
        int rd0, we0;
        @(negedge clk);
        sel_code = sc; irq_src = src; parity_err = perr; susp_pc = pc;
        start = 1'b1;
        rd0 = rd_total; we0 = we_total;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 0;
        while (!out_valid && lat < 20) begin
            @(posedge clk);
            lat++;
            #1;
        end
        rds = rd_total - rd0;
        wes = we_total - we0;
    endtask

    task automatic t_reset();
        chk("R1 out_valid in reset", 32'(out_valid), 0);
        chk("R1 busy in reset", 32'(busy), 0);
        chk("R1 mem_rd in reset", 32'(mem_rd), 0);
        chk("R1 mem_we in reset", 32'(mem_we), 0);
    endtask

    task automatic t_table(input string tag, input logic [5:0] sc, input logic [1:0] src,
                           input logic [15:0] e_entry, input logic [2:0] e_kind,
                           input logic [14:0] e_hand, input int e_rd, input int e_lat);
        do_op(sc, src, 1'b0, 15'h0);
        chk({tag, " latency"}, 32'(lat), 32'(e_lat));
        chk({tag, " reads"}, 32'(rds), 32'(e_rd));
        chk({tag, " entry"}, 32'(out_entry), 32'(e_entry));
        chk({tag, " kind"}, 32'(out_kind), 32'(e_kind));
        chk({tag, " handler"}, 32'(out_handler), 32'(e_hand));
        @(posedge clk); #1;
        chk({tag, " R11 pulse width"}, 32'(out_valid), 0);
    endtask

    task automatic t_prot(input logic perr);
        do_op(6'd20, 2'd2, perr, 15'h1234);
        if (perr) begin
            chk("R8 latency", 32'(lat), 3);
            chk("R8 kind", 32'(out_kind), 5);
            chk("R8 handler", 32'(out_handler), 32'h0999);
            chk("R8 write count", 32'(wes), 1);
            chk("R8 write addr", 32'(last_waddr), 32'h0208);
            chk("R8 write data", 32'(last_wdata), 32'h1234);
            chk("R8 saved word", 32'(mem[10'h208]), 32'h1234);
        end else begin
            chk("R9 latency", 32'(lat), 2);
            chk("R9 kind", 32'(out_kind), 4);
            chk("R9 handler", 32'(out_handler), 32'h0777);
            chk("R9 no write", 32'(wes), 0);
        end
    endtask

    task automatic t_busy();
        int rd0, pulses;
        @(negedge clk);
        sel_code = 6'd7; irq_src = 2'd0; parity_err = 1'b0; start = 1'b1;
        rd0 = rd_total;
        @(posedge clk);
        #1 irq_src = 2'd3;
        lat = 0; pulses = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk);
            #1;
            if (i == 1) start = 1'b0;
            if (out_valid) begin
                pulses++;
                if (pulses == 1) lat = i + 1;
                chk("R12 kind kept", 32'(out_kind), 2);
                chk("R12 handler kept", 32'(out_handler), 32'h0455);
            end
        end
        start = 1'b0;
        chk("R12 single pulse", 32'(pulses), 1);
        chk("R12 latency", 32'(lat), 4);
        chk("R12 read count", 32'(rd_total - rd0), 2);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        mem[10'h100] = 16'h8012;
        mem[10'h101] = 16'h0150;
        mem[10'h102] = 16'h0000;
        mem[10'h103] = 16'h8000;
        mem[10'h104] = 16'h0123;
        mem[10'h105] = 16'h0456;
        mem[10'h203] = 16'h0333;
        mem[10'h204] = 16'h0444;
        mem[10'h205] = 16'h8455;
        mem[10'h206] = 16'h0666;
        mem[10'h207] = 16'h0777;
        mem[10'h209] = 16'h0999;
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        t_reset();

        t_table("R4 R2 negative entry",   6'd6,  2'd0, 16'h8012, 3'd3, 15'h0666, 2, 4);
        t_table("R5 R11 positive entry",  6'd7,  2'd0, 16'h0150, 3'd2, 15'h0455, 2, 4);
        t_table("R6 zero entry",          6'd8,  2'd0, 16'h0000, 3'd1, 15'h0444, 2, 4);
        t_table("R2 index equals length", 6'd10, 2'd0, 16'h0123, 3'd2, 15'h0455, 2, 4);
        t_table("R3 index beyond length", 6'd11, 2'd0, 16'h0000, 3'd1, 15'h0444, 1, 2);
        t_table("R3 code below first",    6'd3,  2'd0, 16'h0000, 3'd1, 15'h0444, 1, 2);
        t_table("R7 DMA strip to device", 6'd6,  2'd1, 16'h0012, 3'd2, 15'h0455, 2, 4);
        t_table("R7 DMA strip to zero",   6'd9,  2'd1, 16'h0000, 3'd1, 15'h0444, 2, 4);
        t_table("R10 timer",              6'd7,  2'd3, 16'h0000, 3'd0, 15'h0333, 1, 2);
        t_prot(1'b0);
        t_prot(1'b1);
        t_busy();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule